// File: doc/BRIEF.md
# Converter Serial Port with Configuration Echo

This block is the device-side serial port of a data converter. An external host selects it with an active-low select line and clocks it with a serial clock. A single output line shows whether a new conversion result is waiting. Within a frame the port shifts out the current 16-bit result, most significant bit first, and at the same time shifts in a 16-bit configuration word. A frame is either 16 or 32 clocks long. In a 32-clock frame the second half returns the configuration register as it stands after the word taken in during the first half.

The port owns the configuration register. A received word is stored only when its two-bit command field holds the write code, and a word that asks for a single conversion produces a start pulse for the conversion logic. The frame resets when select goes high. It also resets when the serial clock stays low for longer than a programmable number of system-clock ticks, so a host can recover from a broken transfer. All pins are sampled on the system clock. Edges of the serial clock are found by comparing each sample with the one before it. The output enable is a separate signal and not a tri-state driver.

Top module: `adcSerialPort`

## Requirements
- R1: After reset the configuration register reads 058Bh. The output enable is low whenever select is high.
- R2: The configuration register is written only when bits [2:1] of the received word equal 01. The values 00, 10 and 11 leave it unchanged.
- R3: A written word is stored with bit 15 cleared and bit 0 set. The write takes effect once the 16th DIN bit has been sampled. If bit 15 of a written word is 1, `ssStart` pulses for exactly one system cycle.
- R4: DIN is sampled on falling serial-clock edges. The result is driven out most significant bit first, and bit 15 appears after the first rising edge.
- R5: In a 32-clock frame, bits 16 to 31 on the output equal the configuration register after the first-half write. DIN bits in the second half have no effect.
- R6: Raising select mid-frame abandons the frame. A partially received word is never stored, and the next frame starts again from bit 15 of the result.
- R7: A serial-clock low time of `TIMEOUT_TICKS` system cycles inside a selected frame resets the frame, and the next rising edge starts a new frame. A shorter low time leaves the frame intact.
- R8: While select is low and before the first rising edge, the output is low when `dataReady` is 1 and high when it is 0.
- R9: `resultTaken` pulses once per frame, on the first rising edge, when the result is captured for shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, or the ready indication before the first bit |
| sdoEn | output | 1 | Output drive enable |
| convData | input | 16 | Latest conversion result |
| dataReady | input | 1 | A new result is waiting |
| cfgWord | output | 16 | Configuration register contents |
| ssStart | output | 1 | One-cycle request for a single conversion |
| resultTaken | output | 1 | One-cycle pulse when the result is captured for a frame |

## Verification
The assertions assume that `csN`, `sclk` and `sdi` are already synchronous to `clk`. They also assume each serial-clock level lasts at least one system cycle and that `sdi` is steady at the system edge that sees the falling edge. The bench changes every pin on the falling edge of the system clock, holds each serial-clock level for three system cycles, and keeps `sclk` low whenever select changes. It also assumes `convData` stays steady around the first rising edge of a frame, and the bench holds it fixed for the whole frame.

// File: rtl/adcSerialPkg.sv
package adcSerialPkg;
  localparam int WORD_W = 16;
  localparam int FRAME_BITS = 2 * WORD_W;
  localparam logic [WORD_W-1:0] CFG_RESET = 16'h058B;
  localparam logic [1:0] WRITE_CODE = 2'b01;

  typedef struct packed {
    logic loadConv;
    logic loadEcho;
    logic shiftOut;
    logic sampleIn;
    logic commitCfg;
  } strobes_t;
endpackage

// File: rtl/adcSerialCtrl.sv
module adcSerialCtrl
  import adcSerialPkg::*;
#(
  parameter int TIMEOUT_TICKS = 2800000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     sclk,
  output strobes_t strobes,
  output logic     frameActive
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int TO_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic sclkQ, started;
  logic [CNT_W-1:0] bitCnt;
  logic [TO_W-1:0] toCnt;
  logic rise, fall, timeoutHit, sel;

  assign rise = sclk && !sclkQ;
  assign fall = !sclk && sclkQ;
  assign timeoutHit = !csN && !sclk && (toCnt == TO_LAST);
  assign sel = !csN && !timeoutHit;

  always_comb begin
    strobes = '0;
    strobes.loadConv  = sel && rise && !started;
    strobes.loadEcho  = sel && rise && started && (bitCnt == HALF);
    strobes.shiftOut  = sel && rise && started && (bitCnt != HALF);
    strobes.sampleIn  = sel && fall && (bitCnt < HALF);
    strobes.commitCfg = sel && fall && (bitCnt == HALF - 1'b1);
  end

  assign frameActive = started;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      started <= 1'b0;
      bitCnt  <= '0;
      toCnt   <= '0;
    end else begin
      sclkQ <= sclk;
      if (!sel) begin
        started <= 1'b0;
        bitCnt  <= '0;
      end else begin
        if (rise && !started) started <= 1'b1;
        if (fall && bitCnt < FULL) bitCnt <= bitCnt + 1'b1;
      end
      if (csN || sclk || timeoutHit) toCnt <= '0;
      else toCnt <= toCnt + 1'b1;
    end
  end

  // R6: deselection clears the frame state
  a_r6_deselect_clears: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!started && bitCnt == '0));
  // R4: the sample counter never passes one full frame
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL);
  // R7: a full idle-low window ends the frame
  a_r7_timeout_resets: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !sclk && toCnt == TO_LAST) |=> (!started && bitCnt == '0));
endmodule

// File: rtl/adcSerialData.sv
module adcSerialData
  import adcSerialPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              frameActive,
  input  logic              sdi,
  input  logic [WORD_W-1:0] convData,
  input  logic              dataReady,
  output logic              sdo,
  output logic [WORD_W-1:0] cfgWord,
  output logic              ssStart,
  output logic              resultTaken
);
  logic [WORD_W-1:0] outShift, rxShift, cfgReg, newWord;
  logic nopOk;

  assign newWord = {rxShift[WORD_W-2:0], sdi};
  assign nopOk = (newWord[2:1] == WRITE_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift    <= '0;
      rxShift     <= '0;
      cfgReg      <= CFG_RESET;
      ssStart     <= 1'b0;
      resultTaken <= 1'b0;
    end else begin
      ssStart     <= 1'b0;
      resultTaken <= 1'b0;
      if (strobes.loadConv) begin
        outShift    <= convData;
        resultTaken <= 1'b1;
      end else if (strobes.loadEcho) begin
        outShift <= cfgReg;
      end else if (strobes.shiftOut) begin
        outShift <= {outShift[WORD_W-2:0], 1'b0};
      end
      if (strobes.sampleIn) rxShift <= newWord;
      if (strobes.commitCfg && nopOk) begin
        cfgReg  <= {1'b0, newWord[WORD_W-2:1], 1'b1};
        ssStart <= newWord[WORD_W-1];
      end
    end
  end

  assign sdo = frameActive ? outShift[WORD_W-1] : !dataReady;
  assign cfgWord = cfgReg;

  // R2: a word without the write code leaves the register alone
  a_r2_nop_gate: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitCfg && !nopOk) |=> $stable(cfgReg));
  // R5: the second half starts from the register state
  a_r5_echo_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEcho |=> (outShift == $past(cfgReg)));
  // R3: a start pulse only follows a commit, and bit 15 is never stored
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ssStart |-> (!cfgReg[WORD_W-1] && $past(strobes.commitCfg)));
endmodule

// File: rtl/adcSerialPort.sv
module adcSerialPort
  import adcSerialPkg::*;
#(
  parameter int TIMEOUT_TICKS = 2800000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdoEn,
  input  logic [15:0] convData,
  input  logic        dataReady,
  output logic [15:0] cfgWord,
  output logic        ssStart,
  output logic        resultTaken
);
  strobes_t strobes;
  logic frameActive;

  adcSerialCtrl #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .strobes(strobes), .frameActive(frameActive)
  );

  adcSerialData uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .frameActive(frameActive),
    .sdi(sdi), .convData(convData), .dataReady(dataReady), .sdo(sdo),
    .cfgWord(cfgWord), .ssStart(ssStart), .resultTaken(resultTaken)
  );

  assign sdoEn = !csN;

  // R1: the output is released whenever select is high
  a_r1_release: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sdoEn);
endmodule

// File: tb/tb_adcSerialPort.sv
module tb_adcSerialPort;
  localparam int TO = 64;
  localparam int HALF = 3;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] convData = '0;
  logic dataReady = 1'b0;
  logic sdo, sdoEn, ssStart, resultTaken;
  logic [15:0] cfgWord;
  int nRun = 0, nFail = 0, takenCnt = 0, ssCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adcSerialPort #(.TIMEOUT_TICKS(TO)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdoEn(sdoEn), .convData(convData), .dataReady(dataReady),
    .cfgWord(cfgWord), .ssStart(ssStart), .resultTaken(resultTaken)
  );

  always @(negedge clk) begin
    if (resultTaken) takenCnt++;
    if (ssStart) ssCnt++;
  end

  typedef struct packed {
    logic [15:0] conv;
    logic [15:0] din;
    logic [15:0] din2;
    logic        long;
    logic        rdy;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h8001, 16'hC28B, 16'h0000, 1'b0, 1'b1},
    '{16'h7FFF, 16'h1E6D, 16'hFFFF, 1'b1, 1'b0},
    '{16'h0000, 16'h3AE3, 16'h0000, 1'b1, 1'b1},
    '{16'hA5C3, 16'h05FF, 16'h0000, 1'b0, 1'b0},
    '{16'h0F0F, 16'h8112, 16'h7777, 1'b1, 1'b1},
    '{16'hFFFF, 16'h0001, 16'h058B, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bits(input logic [31:0] dinAll, input int first, input int count,
                      inout logic [31:0] got);
    for (int i = first; i < first + count; i++) begin
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      got = {got[30:0], sdo};
      sdi = dinAll[31-i];
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic select();
    csN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic deselect();
    csN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] model(input logic [15:0] prev, input logic [15:0] w);
    return (w[2:1] == 2'b01) ? {1'b0, w[14:1], 1'b1} : prev;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] expCfg;
    logic [31:0] got;
    int t0, s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(cfgWord == 16'h058B, "R1 reset value", cfgWord, 16'h058B);
    check(sdoEn == 1'b0, "R1 released while deselected", sdoEn, 0);
    expCfg = 16'h058B;

    foreach (VECS[k]) begin
      convData = VECS[k].conv;
      dataReady = VECS[k].rdy;
      t0 = takenCnt;
      s0 = ssCnt;
      select();
      check(sdoEn == 1'b1, "R1 driven while selected", sdoEn, 1);
      check(sdo == !VECS[k].rdy, "R8 ready indication", sdo, !VECS[k].rdy);
      got = '0;
      bits({VECS[k].din, VECS[k].din2}, 0, VECS[k].long ? 32 : 16, got);
      if (VECS[k].din[2:1] == 2'b01 && VECS[k].din[15]) s0++;
      expCfg = model(expCfg, VECS[k].din);
      if (VECS[k].long) begin
        check(got[31:16] == VECS[k].conv, "R4 result MSB first", got[31:16], VECS[k].conv);
        check(got[15:0] == expCfg, "R5 config echo", got[15:0], expCfg);
      end else begin
        check(got[15:0] == VECS[k].conv, "R4 result MSB first", got[15:0], VECS[k].conv);
      end
      deselect();
      check(cfgWord == expCfg, "R2 write gating", cfgWord, expCfg);
      check(ssCnt == s0, "R3 single start pulse", ssCnt, s0);
      check(takenCnt == t0 + 1, "R9 one capture per frame", takenCnt, t0 + 1);
    end
    check(cfgWord[15] == 1'b0 && cfgWord[0] == 1'b1, "R3 stored bit 15 and bit 0", cfgWord, 16'h0113);

    // R6: abort after 10 bits of a valid word
    convData = 16'h9C31;
    select();
    got = '0;
    bits({16'h0083, 16'h0}, 0, 10, got);
    deselect();
    check(sdoEn == 1'b0, "R6 released after abort", sdoEn, 0);
    check(cfgWord == expCfg, "R6 partial word not stored", cfgWord, expCfg);
    select();
    got = '0;
    bits({16'h0083, 16'h0}, 0, 16, got);
    deselect();
    expCfg = model(expCfg, 16'h0083);
    check(got[15:0] == 16'h9C31, "R6 restart at bit 15", got[15:0], 16'h9C31);
    check(cfgWord == expCfg, "R6 full word after abort", cfgWord, expCfg);

    // R7: long idle low resets the frame
    convData = 16'h5A3C;
    select();
    got = '0;
    bits({16'h0FFB, 16'h0}, 0, 8, got);
    repeat (TO + 20) @(negedge clk);
    got = '0;
    bits({16'h6A0B, 16'h0}, 0, 16, got);
    deselect();
    expCfg = model(expCfg, 16'h6A0B);
    check(got[15:0] == 16'h5A3C, "R7 new frame after timeout", got[15:0], 16'h5A3C);
    check(cfgWord == expCfg, "R7 word after timeout", cfgWord, expCfg);

    // R7: short idle low keeps the frame
    select();
    got = '0;
    bits({16'h2203, 16'h0}, 0, 8, got);
    repeat (TO - 20) @(negedge clk);
    bits({16'h2203, 16'h0}, 8, 8, got);
    deselect();
    expCfg = model(expCfg, 16'h2203);
    check(got[15:0] == 16'h5A3C, "R7 short pause keeps data", got[15:0], 16'h5A3C);
    check(cfgWord == expCfg, "R7 short pause keeps word", cfgWord, expCfg);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule